// File: doc/BRIEF.md
# Double-Precision to Wrapping Int32 Converter

This block turns a 64-bit IEEE-754 double into a 32-bit two's-complement integer. It truncates toward zero. When the value does not fit, it does not saturate: it keeps the low 32 bits of the signed integer part, which is arithmetic modulo 2^32. It also reports whether the conversion was exact and in range. That report is a single Z condition flag, with N, C and V always cleared. Three single-cycle exception strobes are raised alongside it: invalid, inexact and input-denormal.

A conversion starts when a request is presented with `op_valid` high, together with a flush-inputs-to-zero control. The flush control decides whether a subnormal operand counts as an input-denormal event or as an inexact one.

The conversion datapath is combinational. A parameter adds an output register stage, which is on by default. With the register stage, results appear one clock after the request. The result and Z flag then hold until the next request, while the strobes and `res_valid` pulse for exactly one cycle.

Top module: `dti_wrap_cvt`

## Requirements
- R1: An operand with exponent field 0 and fraction 0 (signed zero) gives result 0 and no strobe. Z is 1 for +0 and 0 for -0.
- R2: An operand with exponent field 0, a nonzero fraction and `flush_in`=1 gives result 0. It raises only `exc_idenorm`. Z equals the inverse of the sign bit (bit 63).
- R3: An operand with exponent field 0, a nonzero fraction and `flush_in`=0 gives result 0. It raises only `exc_inexact`, and Z is 0.
- R4: An operand with exponent field 0x7FF (bits 62:52, infinity or NaN) gives result 0. It raises only `exc_invalid`, and Z is 0.
- R5: A normal operand whose integer part lies in [-2^31, 2^31-1] with no fractional bits gives that integer. Z is 1 and no strobe is raised.
- R6: A normal operand in range with discarded fraction bits gives the integer part truncated toward zero (for example -1.5 gives 0xFFFFFFFF). It raises `exc_inexact`, and Z is 0.
- R7: A normal operand with magnitude below 1, including magnitudes below 2^-12, gives result 0 with `exc_inexact` and Z=0.
- R8: A normal operand is out of range when its unbiased exponent exceeds 31, or when its truncated magnitude exceeds 0x7FFFFFFF (positive) or 0x80000000 (negative). It then raises `exc_invalid` and not `exc_inexact`, and Z is 0. The result is the low 32 bits of the signed truncated integer, or 0 when the binary point lies 64 or more places right of the 53-bit significand.
- R9: -2^31 converts to 0x80000000 with Z=1 and no strobe. +2^31 converts to 0x80000000 with `exc_invalid` and Z=0.
- R10: `flag_n`, `flag_c` and `flag_v` are 0 at all times.
- R11: With the output register, `res_valid` and the strobes follow `op_valid` by one clock. The strobes are 0 in any cycle without a result. `result` and `flag_z` hold their last value while `op_valid` is low.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the system |
| op_valid | input | 1 | A conversion request is present this cycle |
| op_bits | input | 64 | Double-precision operand (sign 63, exponent 62:52, fraction 51:0) |
| flush_in | input | 1 | Treat subnormal operands as flushed (input-denormal instead of inexact) |
| res_valid | output | 1 | Result of a request is presented this cycle |
| result | output | 32 | Truncated, wrapped 32-bit signed integer |
| flag_n | output | 1 | Negative condition flag, always 0 |
| flag_z | output | 1 | 1 when the conversion was exact and in range |
| flag_c | output | 1 | Carry condition flag, always 0 |
| flag_v | output | 1 | Overflow condition flag, always 0 |
| exc_invalid | output | 1 | Invalid-operation strobe |
| exc_inexact | output | 1 | Inexact strobe |
| exc_idenorm | output | 1 | Input-denormal strobe |

## Verification
A fault in the alignment shifter shows at the ports in the very next valid cycle. A wrong shift count or a bad lost-bit detector produces a wrong low word, or flips Z against `exc_inexact`. Operands chosen just inside and just outside each shift and range boundary make such a fault visible in a single conversion. The range decision is tested at the asymmetric ±2^31 edge and at exponents between 32 and 52, where wrapping keeps nonzero low bits. A range-decision fault there swaps `exc_invalid` and `exc_inexact` or corrupts the wrapped value on the same cycle. A fault in the output register's enable appears as a result or Z that changes during idle cycles, or as strobes that persist. The per-clock comparison catches it one cycle after the idle cycle begins.

// File: rtl/dti_pkg.sv
package dti_pkg;

  localparam int unsigned DTI_EXP_W  = 11;
  localparam int unsigned DTI_FRAC_W = 52;
  localparam int unsigned DTI_INT_W  = 32;
  localparam int unsigned DTI_ACC_W  = 64;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_SUBN = 2'd1,
    CLS_NORM = 2'd2,
    CLS_SPEC = 2'd3
  } dti_class_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
    logic idenorm;
  } dti_exc_t;

endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
  import dti_pkg::*;
#(
  parameter int unsigned EXP_W  = DTI_EXP_W,
  parameter int unsigned FRAC_W = DTI_FRAC_W,
  localparam int unsigned OP_W  = EXP_W + FRAC_W + 1,
  localparam int unsigned SX_W  = EXP_W + 2
) (
  input  logic [OP_W-1:0]        op_bits,
  output logic                   sign,
  output dti_class_e             cls,
  output logic [FRAC_W:0]        mant,
  output logic signed [SX_W-1:0] uexp
);

  localparam logic signed [SX_W-1:0] BIAS = SX_W'((2 ** (EXP_W - 1)) - 1);

  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] frac_fld;
  logic              exp_lo;
  logic              exp_hi;
  logic              frac_nz;

  assign sign     = op_bits[OP_W-1];
  assign exp_fld  = op_bits[OP_W-2:FRAC_W];
  assign frac_fld = op_bits[FRAC_W-1:0];

  assign exp_lo  = (exp_fld == '0);
  assign exp_hi  = (exp_fld == '1);
  assign frac_nz = |frac_fld;

  // classification: the all-ones exponent wins, then the zero exponent
  always_comb begin
    if (exp_hi)              cls = CLS_SPEC;
    else if (!exp_lo)        cls = CLS_NORM;
    else if (frac_nz)        cls = CLS_SUBN;
    else                     cls = CLS_ZERO;
  end

  // hidden one restored for normal operands
  assign mant = {1'b1, frac_fld};
  assign uexp = $signed({2'b00, exp_fld}) - BIAS;

endmodule

// File: rtl/dti_align.sv
module dti_align #(
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned SX_W   = 13,
  parameter int unsigned ACC_W  = 64
) (
  input  logic [FRAC_W:0]        mant,
  input  logic signed [SX_W-1:0] uexp,
  output logic [ACC_W-1:0]       mag,
  output logic                   lost
);

  localparam int unsigned PAD_W = ACC_W - FRAC_W - 1;
  localparam logic signed [SX_W-1:0] FW_S = SX_W'(FRAC_W);

  logic [ACC_W-1:0]       wide;
  logic signed [SX_W-1:0] shamt;
  int                     sh_i;
  int                     rs_i;

  generate
    if (PAD_W > 0) begin : g_pad
      assign wide = {{PAD_W{1'b0}}, mant};
    end else begin : g_nopad
      assign wide = ACC_W'(mant);
    end
  endgenerate

  // binary point position relative to the significand's lsb
  assign shamt = uexp - FW_S;

  always_comb begin
    sh_i = int'(shamt);
    rs_i = 0;
    mag  = '0;
    lost = 1'b1;
    if (sh_i >= 0) begin
      // integer bits only; anything beyond the accumulator vanishes
      if (sh_i < int'(ACC_W)) mag = wide << sh_i;
      lost = 1'b1;
    end else begin
      rs_i = -sh_i;
      if (rs_i < int'(ACC_W)) begin
        mag  = wide >> rs_i;
        lost = |(wide << (int'(ACC_W) - rs_i));
      end else begin
        mag  = '0;
        lost = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dti_judge.sv
module dti_judge
  import dti_pkg::*;
#(
  parameter int unsigned INT_W = DTI_INT_W,
  parameter int unsigned SX_W  = 13,
  parameter int unsigned ACC_W = DTI_ACC_W
) (
  input  logic                   sign,
  input  dti_class_e             cls,
  input  logic                   flush_in,
  input  logic signed [SX_W-1:0] uexp,
  input  logic [ACC_W-1:0]       mag,
  input  logic                   lost,
  output logic [INT_W-1:0]       res,
  output logic                   exact,
  output dti_exc_t               exc
);

  localparam logic signed [SX_W-1:0] TOP_EXP = SX_W'(INT_W - 1);
  localparam logic [ACC_W-1:0] LIM_NEG =
    {{(ACC_W - INT_W){1'b0}}, 1'b1, {(INT_W - 1){1'b0}}};
  localparam logic [ACC_W-1:0] LIM_POS = LIM_NEG - 1'b1;

  logic             exp_big;
  logic             mag_big;
  logic             over;
  logic [INT_W-1:0] low_mag;
  logic [INT_W-1:0] wrapped;
  logic             ind;

  assign exp_big = (uexp > TOP_EXP);
  assign mag_big = sign ? (mag > LIM_NEG) : (mag > LIM_POS);
  assign over    = exp_big | mag_big;

  // low word of a two's-complement negation needs only the low word
  assign low_mag = mag[INT_W-1:0];
  assign wrapped = sign ? (~low_mag + 1'b1) : low_mag;

  always_comb begin
    res = '0;
    ind = 1'b1;
    exc = '0;
    unique case (cls)
      CLS_ZERO: begin
        ind = sign;
      end
      CLS_SUBN: begin
        if (flush_in) begin
          ind         = sign;
          exc.idenorm = 1'b1;
        end else begin
          ind         = 1'b1;
          exc.inexact = 1'b1;
        end
      end
      CLS_SPEC: begin
        ind         = 1'b1;
        exc.invalid = 1'b1;
      end
      default: begin
        res = wrapped;
        if (over) begin
          ind         = 1'b1;
          exc.invalid = 1'b1;
        end else begin
          ind         = lost;
          exc.inexact = lost;
        end
      end
    endcase
  end

  assign exact = ~ind;

endmodule

// File: rtl/dti_wrap_cvt.sv
module dti_wrap_cvt
  import dti_pkg::*;
#(
  parameter int unsigned EXP_W   = DTI_EXP_W,
  parameter int unsigned FRAC_W  = DTI_FRAC_W,
  parameter int unsigned INT_W   = DTI_INT_W,
  parameter int unsigned ACC_W   = DTI_ACC_W,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned OP_W   = EXP_W + FRAC_W + 1,
  localparam int unsigned SX_W   = EXP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_bits,
  input  logic             flush_in,
  output logic             res_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic             exc_invalid,
  output logic             exc_inexact,
  output logic             exc_idenorm
);

  logic                   u_sign;
  dti_class_e             u_cls;
  logic [FRAC_W:0]        u_mant;
  logic signed [SX_W-1:0] u_uexp;
  logic [ACC_W-1:0]       a_mag;
  logic                   a_lost;
  logic [INT_W-1:0]       c_res;
  logic                   c_exact;
  dti_exc_t               c_exc;
  dti_exc_t               c_exc_g;

  dti_unpack #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
  ) u_unpack (
    .op_bits (op_bits),
    .sign    (u_sign),
    .cls     (u_cls),
    .mant    (u_mant),
    .uexp    (u_uexp)
  );

  dti_align #(
    .FRAC_W (FRAC_W),
    .SX_W   (SX_W),
    .ACC_W  (ACC_W)
  ) u_align (
    .mant (u_mant),
    .uexp (u_uexp),
    .mag  (a_mag),
    .lost (a_lost)
  );

  dti_judge #(
    .INT_W (INT_W),
    .SX_W  (SX_W),
    .ACC_W (ACC_W)
  ) u_judge (
    .sign     (u_sign),
    .cls      (u_cls),
    .flush_in (flush_in),
    .uexp     (u_uexp),
    .mag      (a_mag),
    .lost     (a_lost),
    .res      (c_res),
    .exact    (c_exact),
    .exc      (c_exc)
  );

  // strobes exist only for a presented request
  assign c_exc_g = op_valid ? c_exc : '0;

  assign flag_n = 1'b0;
  assign flag_c = 1'b0;
  assign flag_v = 1'b0;

  generate
    if (OUT_REG) begin : g_reg
      logic             q_vld,  n_vld;
      logic [INT_W-1:0] q_res,  n_res;
      logic             q_z,    n_z;
      dti_exc_t         q_exc,  n_exc;
      logic             ld_en;

      assign ld_en = op_valid;

      always_comb begin
        n_vld = op_valid;
        n_exc = c_exc_g;
        n_res = ld_en ? c_res   : q_res;
        n_z   = ld_en ? c_exact : q_z;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_vld <= 1'b0;
          q_res <= '0;
          q_z   <= 1'b0;
          q_exc <= '0;
        end else begin
          q_vld <= n_vld;
          q_res <= n_res;
          q_z   <= n_z;
          q_exc <= n_exc;
        end
      end

      assign res_valid   = q_vld;
      assign result      = q_res;
      assign flag_z      = q_z;
      assign exc_invalid = q_exc.invalid;
      assign exc_inexact = q_exc.inexact;
      assign exc_idenorm = q_exc.idenorm;

      p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

      p_strobe_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_invalid | exc_inexact | exc_idenorm) |-> res_valid);

      p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(flag_z)));

      p_invalid_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_invalid |-> (!exc_inexact && !exc_idenorm && !flag_z));

      p_denorm_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_idenorm |-> (result == '0 && !exc_inexact));

      p_inexact_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_inexact |-> !flag_z);
    end else begin : g_comb
      assign res_valid   = op_valid;
      assign result      = c_res;
      assign flag_z      = c_exact;
      assign exc_invalid = c_exc_g.invalid;
      assign exc_inexact = c_exc_g.inexact;
      assign exc_idenorm = c_exc_g.idenorm;
    end
  endgenerate

endmodule

// File: tb/tb_dti_wrap_cvt.sv
`timescale 1ns/1ps
module tb_dti_wrap_cvt;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [63:0] op_bits;
  logic        flush_in;
  logic        res_valid;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic        exc_invalid, exc_inexact, exc_idenorm;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // model state, one clock behind the request
  logic        m_vld, m_z, m_inv, m_inx, m_idn;
  logic [31:0] m_res;

  typedef struct packed {
    logic [31:0] res;
    logic        z;
    logic        inv;
    logic        inx;
    logic        idn;
  } ref_t;

  dti_wrap_cvt dut (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_bits (op_bits),
    .flush_in (flush_in), .res_valid (res_valid), .result (result),
    .flag_n (flag_n), .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v),
    .exc_invalid (exc_invalid), .exc_inexact (exc_inexact),
    .exc_idenorm (exc_idenorm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic ref_t conv_ref(logic [63:0] b, logic fz);
    ref_t        r;
    logic        s;
    int          e;
    logic [63:0] m;
    logic        ind;
    logic        drop;
    int          sh;
    s   = b[63];
    e   = int'(b[62:52]);
    m   = {12'd0, b[51:0]};
    ind = 1'b1;
    r   = '0;
    if (e == 0) begin
      ind = s;
      if (m != 0) begin
        if (fz) r.idn = 1'b1;
        else begin r.inx = 1'b1; ind = 1'b1; end
      end
      m = 0;
    end else if (e == 2047) begin
      r.inv = 1'b1;
      m = 0;
    end else begin
      m[52] = 1'b1;
      sh = e - 1075;
      if (sh >= 64) m = 0;
      else if (sh >= 0) m = m << sh;
      else if (sh > -64) begin
        drop = 1'b0;
        for (int k = 0; k < -sh; k++) begin
          drop = drop | m[0];
          m = m >> 1;
        end
        ind = drop;
      end else m = 0;
      if ((e - 1023) > 31 || m > (s ? 64'h8000_0000 : 64'h7FFF_FFFF)) begin
        r.inv = 1'b1;
        ind = 1'b1;
      end else r.inx = ind;
      if (s) m = 64'd0 - m;
    end
    r.res = m[31:0];
    r.z   = ~ind;
    return r;
  endfunction

  task automatic check_out(string tag);
    n_checks++;
    if (res_valid !== m_vld || result !== m_res || flag_z !== m_z ||
        exc_invalid !== m_inv || exc_inexact !== m_inx || exc_idenorm !== m_idn) begin
      n_fail++;
      $display("FAIL %s: got vld=%b res=%h z=%b inv=%b inx=%b idn=%b, expected vld=%b res=%h z=%b inv=%b inx=%b idn=%b",
               tag, res_valid, result, flag_z, exc_invalid, exc_inexact, exc_idenorm,
               m_vld, m_res, m_z, m_inv, m_inx, m_idn);
    end
    n_checks++;
    if ({flag_n, flag_c, flag_v} !== 3'b000) begin
      n_fail++;
      $display("FAIL R10: got ncv=%b expected 000", {flag_n, flag_c, flag_v});
    end
  endtask

  // drive just after a falling edge, compare at the next falling edge
  task automatic step(logic v, logic [63:0] b, logic fz, string tag);
    ref_t r;
    op_valid = v;
    op_bits  = b;
    flush_in = fz;
    if (v) begin
      r = conv_ref(b, fz);
      m_vld = 1'b1; m_res = r.res; m_z = r.z;
      m_inv = r.inv; m_inx = r.inx; m_idn = r.idn;
    end else begin
      m_vld = 1'b0; m_inv = 1'b0; m_inx = 1'b0; m_idn = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check_out(tag);
  endtask

  // fixed expectations written from the requirements
  task automatic expect_fixed(logic [63:0] b, logic fz, logic [31:0] er,
                              logic ez, logic ei, logic ex, logic ed, string tag);
    step(1'b1, b, fz, tag);
    n_checks++;
    if (result !== er || flag_z !== ez || exc_invalid !== ei ||
        exc_inexact !== ex || exc_idenorm !== ed) begin
      n_fail++;
      $display("FAIL %s: got res=%h z=%b inv=%b inx=%b idn=%b, expected res=%h z=%b inv=%b inx=%b idn=%b",
               tag, result, flag_z, exc_invalid, exc_inexact, exc_idenorm,
               er, ez, ei, ex, ed);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    rst_n = 1'b0; op_valid = 1'b0; op_bits = '0; flush_in = 1'b0;
    m_vld = 0; m_res = 0; m_z = 0; m_inv = 0; m_inx = 0; m_idn = 0;
    @(negedge clk);
    op_valid = 1'b1; op_bits = 64'h3FF0_0000_0000_0000;
    @(negedge clk); check_out("R12 reset");
    @(negedge clk); check_out("R12 reset");
    op_valid = 1'b0;
    rst_n = 1'b1;

    expect_fixed(64'h0000_0000_0000_0000, 1'b0, 32'h0, 1, 0, 0, 0, "R1 +0");
    expect_fixed(64'h8000_0000_0000_0000, 1'b0, 32'h0, 0, 0, 0, 0, "R1 -0");
    expect_fixed(64'h000F_FFFF_FFFF_FFFF, 1'b1, 32'h0, 1, 0, 0, 1, "R2 max subnormal flush");
    expect_fixed(64'h800F_FFFF_FFFF_FFFF, 1'b1, 32'h0, 0, 0, 0, 1, "R2 neg subnormal flush");
    expect_fixed(64'h000F_FFFF_FFFF_FFFF, 1'b0, 32'h0, 0, 0, 1, 0, "R3 max subnormal");
    expect_fixed(64'h7FF0_0000_0000_0000, 1'b0, 32'h0, 0, 1, 0, 0, "R4 +inf");
    expect_fixed(64'h7FF8_0000_0000_0000, 1'b0, 32'h0, 0, 1, 0, 0, "R4 nan");
    expect_fixed(64'h4045_0000_0000_0000, 1'b0, 32'd42, 1, 0, 0, 0, "R5 42.0");
    expect_fixed(64'hC01C_0000_0000_0000, 1'b0, 32'hFFFF_FFF9, 1, 0, 0, 0, "R5 -7.0");
    expect_fixed(64'h41DF_FFFF_FFC0_0000, 1'b0, 32'h7FFF_FFFF, 1, 0, 0, 0, "R5 max positive");
    expect_fixed(64'h3FF8_0000_0000_0000, 1'b0, 32'd1, 0, 0, 1, 0, "R6 +1.5");
    expect_fixed(64'hBFF8_0000_0000_0000, 1'b0, 32'hFFFF_FFFF, 0, 0, 1, 0, "R6 -1.5");
    expect_fixed(64'h3FE0_0000_0000_0000, 1'b0, 32'h0, 0, 0, 1, 0, "R7 0.5");
    expect_fixed(64'h3E00_0000_0000_0000, 1'b0, 32'h0, 0, 0, 1, 0, "R7 tiny");
    expect_fixed(64'h4270_0000_0000_5000, 1'b0, 32'd5, 0, 1, 0, 0, "R8 2^40+5 wraps");
    expect_fixed(64'h7FE0_0000_0000_0000, 1'b0, 32'h0, 0, 1, 0, 0, "R8 huge");
    expect_fixed(64'hC1E0_0000_0000_0000, 1'b0, 32'h8000_0000, 1, 0, 0, 0, "R9 -2^31");
    expect_fixed(64'h41E0_0000_0000_0000, 1'b0, 32'h8000_0000, 0, 1, 0, 0, "R9 +2^31");

    // idle cycles: result and Z hold, strobes quiet
    step(1'b1, 64'h3FF8_0000_0000_0000, 1'b0, "R11 load");
    step(1'b0, 64'h4045_0000_0000_0000, 1'b0, "R11 idle hold");
    step(1'b0, 64'h7FF0_0000_0000_0000, 1'b1, "R11 idle hold");

    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] b;
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 7);
      lf = lf ^ (lf << 17);
      b = lf;
      if (i % 3 != 0) b[62:52] = 11'(1000 + (lf[7:0] % 70));
      step(lf[40] | lf[41], b, lf[42], "R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule